// File: doc/BRIEF.md
# Time and Calendar Update Engine

This block holds the eight timekeeping bytes of a real-time clock (seconds, minutes, hours, day of week, date, month, year and century) and advances them by one second at a time. It counts natively in either packed BCD or plain binary. The hours byte can run in 24-hour form or in 12-hour form, where bit 7 flags the afternoon. Month lengths follow the Gregorian leap rule, and the century byte decides the case of a year ending in 00. An optional daylight-saving feature moves the clock forward one hour in spring and back one hour in autumn.

The engine takes a half-second tick from an external divider, together with a three-bit divider control code. It counts the tick phase itself, so an update falls on every second tick. An update is announced on an update-in-progress output for a fixed number of system clocks, then committed. A one-cycle done pulse follows the commit, for use by interrupt logic. Software-style writes go through a single byte-wide write port. A SET control freezes the counts so that they can be loaded consistently.

Top module: `rtc_calendar_engine`

## Requirements
- R1: After reset the bytes read seconds 00h, minutes 00h, hours 00h, day of week 01h, date 01h, month 01h, year 00h and century 20h, with `uip` and `upd_done` low.
- R2: With `bin_mode` = 0, every byte counts in packed BCD: seconds and minutes wrap 59→00 and carry, 24-hour hours wrap 23→00 and carry into the date, and a low digit of 9 carries into the high digit.
- R3: With `bin_mode` = 1, the same counts run in plain binary (seconds 3Bh→00h, hours 17h→00h).
- R4: With `hr24` = 0, hours run 1..12 and bit 7 is set for PM: 11:59:59 AM → 12:00:00 PM (92h in BCD), 12:59:59 PM → 1 PM (81h), 11:59:59 PM → 12 AM (12h) with the date advanced.
- R5: The date wraps after 30 or 31 days according to the month. February has 29 days when the year is a nonzero multiple of 4, or when the year is 00 and the century is a multiple of 4, and otherwise 28.
- R6: Day of week runs 1..7 and wraps 7→1 at midnight. December 31 moves to January 1. Year 99 wraps to 00 and raises the century by one.
- R7: A tick that triggers an update raises `uip` on the next clock for exactly `UIP_CYCLES` cycles. The new values and a one-cycle `upd_done` pulse appear in the cycle in which `uip` falls. The bytes do not change at any other time except by a write.
- R8: While `set_mode` = 1 no update occurs and `uip` stays low. A pending update window is abandoned.
- R9: Divider code `dv` = 010 runs the chain, and every second tick then updates. With `dv` = 11x the chain is held in reset and `uip` is low. The first tick after leaving 11x for 010 updates, which is half a second later. Any other code ignores ticks.
- R10: With `dst_en` = 1, on a Sunday (day of week 1) in April with date ≤ 7, the update from 1:59:59 AM gives 3:00:00 AM. With `dst_en` = 0 it gives 2:00:00.
- R11: With `dst_en` = 1, on a Sunday in October with date ≥ 25, the first update from 1:59:59 AM gives 1:00:00 AM. A second pass through 1:59:59 the same day proceeds to 2:00:00, and the lock clears at the next date change.
- R12: `wr_addr` selects 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year, 7 century. A write lands in the next cycle, and bit 7 of the seconds byte always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| half_tick | input | 1 | One-cycle pulse every half second from the divider |
| dv | input | 3 | Divider control code (010 run, 11x chain reset) |
| set_mode | input | 1 | Update inhibit |
| bin_mode | input | 1 | 1 binary, 0 BCD |
| hr24 | input | 1 | 1 24-hour, 0 12-hour |
| dst_en | input | 1 | Daylight-saving jumps enable |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 3 | Byte select for a write |
| wr_data | input | 8 | Write data |
| sec | output | 8 | Seconds byte |
| min | output | 8 | Minutes byte |
| hour | output | 8 | Hours byte (bit 7 PM in 12-hour form) |
| dow | output | 8 | Day of week byte |
| date | output | 8 | Date byte |
| month | output | 8 | Month byte |
| year | output | 8 | Year byte |
| cent | output | 8 | Century byte |
| uip | output | 1 | Update in progress |
| upd_done | output | 1 | One-cycle pulse after each committed update |

## Verification
The hardest state to reach is the autumn fallback lock. It only matters on a second arrival at 1:59:59 on the same October Sunday, and that normally takes an hour of simulated ticks. The bench gets there by letting the fallback fire once and then rewriting the minutes and seconds back to 59:59. This reproduces the repeat hour within two updates, and the bench then checks that the clock moves on to 2:00:00. Phase alignment of the half-second divider is reached by cycling the divider code through its reset pattern and checking that the first tick updates and the next one does not.

// File: rtl/rtc_cal_pkg.sv
// Shared types and number-format helpers for the calendar engine.
// Assumes all stored bytes are either packed BCD or plain binary, never mixed.
package rtc_cal_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 7;

    typedef enum logic [2:0] {
        IDX_SEC   = 3'd0,
        IDX_MIN   = 3'd1,
        IDX_HOUR  = 3'd2,
        IDX_DOW   = 3'd3,
        IDX_DATE  = 3'd4,
        IDX_MONTH = 3'd5,
        IDX_YEAR  = 3'd6,
        IDX_CENT  = 3'd7
    } reg_idx_e;

    typedef struct packed {
        logic [BYTE_W-1:0] sec;
        logic [BYTE_W-1:0] min;
        logic [BYTE_W-1:0] hour;
        logic [BYTE_W-1:0] dow;
        logic [BYTE_W-1:0] date;
        logic [BYTE_W-1:0] month;
        logic [BYTE_W-1:0] year;
        logic [BYTE_W-1:0] cent;
    } cal_regs_t;

    // Packed BCD byte to a binary count.
    function automatic logic [CNT_W-1:0] bcd_to_bin(input logic [BYTE_W-1:0] v);
        int t;
        t = int'(v[7:4]) * 10 + int'(v[3:0]);
        return CNT_W'(t);
    endfunction

    // Binary count (0..99) to a packed BCD byte.
    function automatic logic [BYTE_W-1:0] bin_to_bcd(input logic [CNT_W-1:0] n);
        int t;
        t = int'(n);
        return {4'(t / 10), 4'(t % 10)};
    endfunction

    // Stored byte to a count, in the selected data mode.
    function automatic logic [CNT_W-1:0] to_count(input logic [BYTE_W-1:0] v, input logic bin);
        return bin ? v[CNT_W-1:0] : bcd_to_bin(v);
    endfunction

    // Count to a stored byte, in the selected data mode.
    function automatic logic [BYTE_W-1:0] to_byte(input logic [CNT_W-1:0] n, input logic bin);
        return bin ? {1'b0, n} : bin_to_bcd(n);
    endfunction

    // Number of days in a month (1..12), given the leap flag.
    function automatic logic [CNT_W-1:0] month_len(input logic [CNT_W-1:0] mo, input logic leap);
        logic [CNT_W-1:0] r;
        case (mo)
            7'd4, 7'd6, 7'd9, 7'd11: r = 7'd30;
            7'd2:                    r = leap ? 7'd29 : 7'd28;
            default:                 r = 7'd31;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rtc_tick_seq.sv
// Half-second phase tracker and update-window sequencer.
// Tracks which half-second tick closes a second, raises the update-in-progress
// flag for UIP_CYCLES clocks and strobes the commit on the last of them.
// Assumes half_tick pulses are far more than UIP_CYCLES clocks apart.
module rtc_tick_seq #(
    parameter int UIP_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       half_tick,
    input  logic [2:0] dv,
    input  logic       set_mode,
    output logic       uip,
    output logic       upd_strobe
);
    localparam int CW = $clog2(UIP_CYCLES + 1);
    localparam logic [2:0] DV_RUN = 3'b010;

    logic          phase_q;
    logic [CW-1:0] cnt_q;
    logic          run;
    logic          chain_rst;

    assign run       = (dv == DV_RUN);
    assign chain_rst = (dv[2:1] == 2'b11);

    // Phase, window flag and window counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= 1'b1;
            uip     <= 1'b0;
            cnt_q   <= '0;
        end else if (chain_rst) begin
            phase_q <= 1'b1;
            uip     <= 1'b0;
        end else if (run) begin
            if (half_tick) phase_q <= ~phase_q;
            if (uip) begin
                if (set_mode || cnt_q == '0) uip <= 1'b0;
                else cnt_q <= cnt_q - CW'(1);
            end else if (half_tick && phase_q && !set_mode) begin
                uip   <= 1'b1;
                cnt_q <= CW'(UIP_CYCLES - 1);
            end
        end else begin
            uip <= 1'b0;
        end
    end

    // Commit on the final cycle of an uninterrupted window.
    assign upd_strobe = uip && (cnt_q == '0) && run && !set_mode;

    AST_SET_CLEARS_UIP: assert property (@(posedge clk) disable iff (!rst_n)
        set_mode |=> !uip); // R8
    AST_CHAIN_RESET_NO_UIP: assert property (@(posedge clk) disable iff (!rst_n)
        (dv[2:1] == 2'b11) |=> !uip); // R9

endmodule

// File: rtl/rtc_time_next.sv
// Combinational next-second calculator.
// Decodes the current bytes, advances them by one second (with daylight-saving
// jumps and leap rules), and re-encodes in the same data and hour modes.
// Assumes the current bytes hold legal values for the selected modes.
module rtc_time_next
    import rtc_cal_pkg::*;
(
    input  cal_regs_t cur,
    input  logic      bin_mode,
    input  logic      hr24,
    input  logic      dst_en,
    input  logic      fall_done,
    output cal_regs_t nxt,
    output logic      fall_hit,
    output logic      day_rolled
);
    logic [CNT_W-1:0] s, m, h24, h12, wd, dt, mo, yr, ce;
    logic [CNT_W-1:0] ns, nm, nh, nwd, ndt, nmo, nyr, nce, nh12;
    logic             pm, leap, at_159, spring;
    logic [BYTE_W-1:0] hbyte;

    // Decode every byte into binary counts and a 24-hour value.
    always_comb begin
        s   = to_count(cur.sec, bin_mode);
        m   = to_count(cur.min, bin_mode);
        wd  = to_count(cur.dow, bin_mode);
        dt  = to_count(cur.date, bin_mode);
        mo  = to_count(cur.month, bin_mode);
        yr  = to_count(cur.year, bin_mode);
        ce  = to_count(cur.cent, bin_mode);
        pm  = cur.hour[7];
        h12 = to_count({1'b0, cur.hour[6:0]}, bin_mode);
        if (hr24) h24 = to_count(cur.hour, bin_mode);
        else      h24 = ((h12 == 7'd12) ? 7'd0 : h12) + (pm ? 7'd12 : 7'd0);
        leap = (yr != 7'd0) ? (yr[1:0] == 2'b00) : (ce[1:0] == 2'b00);
    end

    // Detect the two daylight-saving instants.
    always_comb begin
        at_159   = (h24 == 7'd1) && (m == 7'd59) && (s == 7'd59);
        spring   = dst_en && (mo == 7'd4) && (wd == 7'd1) && (dt <= 7'd7) && at_159;
        fall_hit = dst_en && (mo == 7'd10) && (wd == 7'd1) && (dt >= 7'd25) && at_159
                   && !fall_done;
    end

    // Advance the time of day.
    always_comb begin
        ns = s; nm = m; nh = h24; day_rolled = 1'b0;
        if (spring) begin
            ns = 7'd0; nm = 7'd0; nh = 7'd3;
        end else if (fall_hit) begin
            ns = 7'd0; nm = 7'd0; nh = 7'd1;
        end else if (s == 7'd59) begin
            ns = 7'd0;
            if (m == 7'd59) begin
                nm = 7'd0;
                if (h24 == 7'd23) begin
                    nh = 7'd0;
                    day_rolled = 1'b1;
                end else begin
                    nh = h24 + 7'd1;
                end
            end else begin
                nm = m + 7'd1;
            end
        end else begin
            ns = s + 7'd1;
        end
    end

    // Advance the calendar on a day roll.
    always_comb begin
        nwd = wd; ndt = dt; nmo = mo; nyr = yr; nce = ce;
        if (day_rolled) begin
            nwd = (wd >= 7'd7) ? 7'd1 : wd + 7'd1;
            if (dt >= month_len(mo, leap)) begin
                ndt = 7'd1;
                if (mo >= 7'd12) begin
                    nmo = 7'd1;
                    if (yr >= 7'd99) begin
                        nyr = 7'd0;
                        nce = (ce >= 7'd99) ? 7'd0 : ce + 7'd1;
                    end else begin
                        nyr = yr + 7'd1;
                    end
                end else begin
                    nmo = mo + 7'd1;
                end
            end else begin
                ndt = dt + 7'd1;
            end
        end
    end

    // Re-encode, placing the PM flag in 12-hour form.
    always_comb begin
        if (nh == 7'd0)       nh12 = 7'd12;
        else if (nh > 7'd12)  nh12 = nh - 7'd12;
        else                  nh12 = nh;
        if (hr24) hbyte = to_byte(nh, bin_mode);
        else      hbyte = {(nh >= 7'd12), to_byte(nh12, bin_mode)[6:0]};
        nxt.sec   = {1'b0, to_byte(ns, bin_mode)[6:0]};
        nxt.min   = to_byte(nm, bin_mode);
        nxt.hour  = hbyte;
        nxt.dow   = to_byte(nwd, bin_mode);
        nxt.date  = to_byte(ndt, bin_mode);
        nxt.month = to_byte(nmo, bin_mode);
        nxt.year  = to_byte(nyr, bin_mode);
        nxt.cent  = to_byte(nce, bin_mode);
    end

endmodule

// File: rtl/rtc_calendar_engine.sv
// Top of the time and calendar update engine.
// Holds the eight timekeeping bytes, merges byte writes with once-per-second
// updates (a write wins for its own byte), and keeps the autumn fallback lock.
// Assumes software loads consistent values, normally while set_mode is high.
module rtc_calendar_engine
    import rtc_cal_pkg::*;
#(
    parameter int UIP_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       half_tick,
    input  logic [2:0] dv,
    input  logic       set_mode,
    input  logic       bin_mode,
    input  logic       hr24,
    input  logic       dst_en,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic [7:0] sec,
    output logic [7:0] min,
    output logic [7:0] hour,
    output logic [7:0] dow,
    output logic [7:0] date,
    output logic [7:0] month,
    output logic [7:0] year,
    output logic [7:0] cent,
    output logic       uip,
    output logic       upd_done
);
    cal_regs_t regs_q;
    cal_regs_t regs_nxt;
    logic      upd_strobe;
    logic      fall_q;
    logic      fall_hit;
    logic      day_rolled;

    rtc_tick_seq #(.UIP_CYCLES(UIP_CYCLES)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .half_tick  (half_tick),
        .dv         (dv),
        .set_mode   (set_mode),
        .uip        (uip),
        .upd_strobe (upd_strobe)
    );

    rtc_time_next u_next (
        .cur        (regs_q),
        .bin_mode   (bin_mode),
        .hr24       (hr24),
        .dst_en     (dst_en),
        .fall_done  (fall_q),
        .nxt        (regs_nxt),
        .fall_hit   (fall_hit),
        .day_rolled (day_rolled)
    );

    // Byte storage: update commit first, then any write overrides its byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '{sec: 8'h00, min: 8'h00, hour: 8'h00, dow: 8'h01,
                        date: 8'h01, month: 8'h01, year: 8'h00, cent: 8'h20};
        end else begin
            if (upd_strobe) regs_q <= regs_nxt;
            if (wr_en) begin
                case (reg_idx_e'(wr_addr))
                    IDX_SEC:   regs_q.sec   <= {1'b0, wr_data[6:0]};
                    IDX_MIN:   regs_q.min   <= wr_data;
                    IDX_HOUR:  regs_q.hour  <= wr_data;
                    IDX_DOW:   regs_q.dow   <= wr_data;
                    IDX_DATE:  regs_q.date  <= wr_data;
                    IDX_MONTH: regs_q.month <= wr_data;
                    IDX_YEAR:  regs_q.year  <= wr_data;
                    default:   regs_q.cent  <= wr_data;
                endcase
            end
        end
    end

    // Autumn fallback lock: set when the fallback fires, cleared on a date change.
    always_ff @(posedge clk) begin
        if (!rst_n)                       fall_q <= 1'b0;
        else if (upd_strobe && fall_hit)  fall_q <= 1'b1;
        else if (upd_strobe && day_rolled) fall_q <= 1'b0;
    end

    // Completion pulse, aligned with the first cycle of the new values.
    always_ff @(posedge clk) begin
        if (!rst_n) upd_done <= 1'b0;
        else        upd_done <= upd_strobe;
    end

    assign sec   = regs_q.sec;
    assign min   = regs_q.min;
    assign hour  = regs_q.hour;
    assign dow   = regs_q.dow;
    assign date  = regs_q.date;
    assign month = regs_q.month;
    assign year  = regs_q.year;
    assign cent  = regs_q.cent;

    AST_DONE_AT_UIP_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done |-> (!uip && $past(uip))); // R7
    AST_SECONDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_done && !$past(wr_en)) |-> $stable(regs_q.sec)); // R7
    AST_NO_COMMIT_IN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done |-> !$past(set_mode)); // R8
    AST_SEC_MSB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !regs_q.sec[7]); // R12

endmodule

// File: tb/rtc_calendar_engine_test.sv
module rtc_calendar_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int UIPN = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       half_tick = 1'b0;
    logic [2:0] dv = 3'b010;
    logic       set_mode = 1'b0, bin_mode = 1'b0, hr24 = 1'b1, dst_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] sec, min, hour, dow, date, month, year, cent;
    logic       uip, upd_done;
    int n_tests = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_calendar_engine #(.UIP_CYCLES(UIPN)) uut (
        .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .dv(dv),
        .set_mode(set_mode), .bin_mode(bin_mode), .hr24(hr24), .dst_en(dst_en),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sec(sec), .min(min), .hour(hour), .dow(dow), .date(date),
        .month(month), .year(year), .cent(cent), .uip(uip), .upd_done(upd_done)
    );

    task automatic chk(input string req, input string what, input logic [7:0] act,
                       input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic load(input logic [7:0] s, m, h, w, dt, mo, y, c);
        wr(3'd0, s); wr(3'd1, m); wr(3'd2, h); wr(3'd3, w);
        wr(3'd4, dt); wr(3'd5, mo); wr(3'd6, y); wr(3'd7, c);
    endtask

    task automatic pulse_tick();
        @(negedge clk); half_tick = 1'b1;
        @(negedge clk); half_tick = 1'b0;
        repeat (UIPN + 3) @(negedge clk);
    endtask

    // One second: the updating tick followed by the idle tick.
    task automatic second();
        pulse_tick();
        pulse_tick();
    endtask

    task automatic t_reset();
        chk("R1", "sec", sec, 8'h00);   chk("R1", "min", min, 8'h00);
        chk("R1", "hour", hour, 8'h00); chk("R1", "dow", dow, 8'h01);
        chk("R1", "date", date, 8'h01); chk("R1", "month", month, 8'h01);
        chk("R1", "year", year, 8'h00); chk("R1", "cent", cent, 8'h20);
        chk("R1", "uip", {7'd0, uip}, 8'h00);
        chk("R1", "upd_done", {7'd0, upd_done}, 8'h00);
    endtask

    task automatic t_uip_window();
        int cnt = 0;
        wr(3'd0, 8'h09);
        @(negedge clk); half_tick = 1'b1;
        @(negedge clk); half_tick = 1'b0;
        while (uip && cnt < 100) begin
            chk("R7", "sec held during uip", sec, 8'h09);
            cnt++;
            @(negedge clk);
        end
        chk("R7", "uip length", 8'(cnt), 8'(UIPN));
        chk("R7", "upd_done at uip fall", {7'd0, upd_done}, 8'h01);
        chk("R2", "BCD digit carry", sec, 8'h10);
        @(negedge clk);
        chk("R7", "upd_done one cycle", {7'd0, upd_done}, 8'h00);
        repeat (UIPN + 2) @(negedge clk);
        pulse_tick();
    endtask

    task automatic t_bcd_rollover();
        bin_mode = 1'b0; hr24 = 1'b1;
        load(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99, 8'h19);
        second();
        chk("R2", "sec", sec, 8'h00);   chk("R2", "min", min, 8'h00);
        chk("R2", "hour", hour, 8'h00); chk("R6", "dow wrap", dow, 8'h01);
        chk("R6", "date", date, 8'h01); chk("R6", "month", month, 8'h01);
        chk("R6", "year wrap", year, 8'h00); chk("R6", "century", cent, 8'h20);
        load(8'h59, 8'h59, 8'h23, 8'h03, 8'h30, 8'h04, 8'h24, 8'h20);
        second();
        chk("R5", "30-day month date", date, 8'h01);
        chk("R5", "30-day month month", month, 8'h05);
    endtask

    task automatic t_binary();
        bin_mode = 1'b1; hr24 = 1'b1;
        load(8'h3B, 8'h3B, 8'h17, 8'h03, 8'h1C, 8'h02, 8'h18, 8'h14);
        second();
        chk("R3", "sec", sec, 8'h00); chk("R3", "min", min, 8'h00);
        chk("R3", "hour", hour, 8'h00); chk("R3", "dow", dow, 8'h04);
        chk("R5", "leap Feb 29 binary", date, 8'h1D);
        chk("R3", "month", month, 8'h02);
        load(8'h05, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h14);
        second();
        chk("R3", "binary sec +1", sec, 8'h06);
        bin_mode = 1'b0;
    endtask

    task automatic t_twelve_hour();
        bin_mode = 1'b0; hr24 = 1'b0;
        load(8'h59, 8'h59, 8'h91, 8'h02, 8'h15, 8'h06, 8'h23, 8'h20);
        second();
        chk("R4", "11PM to 12AM", hour, 8'h12);
        chk("R4", "date after midnight", date, 8'h16);
        wr(3'd2, 8'h11); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
        second();
        chk("R4", "11AM to 12PM", hour, 8'h92);
        wr(3'd1, 8'h59); wr(3'd0, 8'h59);
        second();
        chk("R4", "12PM to 1PM", hour, 8'h81);
        wr(3'd2, 8'h12); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
        second();
        chk("R4", "12AM to 1AM", hour, 8'h01);
        hr24 = 1'b1;
    endtask

    task automatic t_leap();
        bin_mode = 1'b0; hr24 = 1'b1;
        load(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h00, 8'h21);
        second();
        chk("R5", "2100 not leap month", month, 8'h03);
        chk("R5", "2100 not leap date", date, 8'h01);
        load(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h00, 8'h20);
        second();
        chk("R5", "2000 leap", date, 8'h29);
        load(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23, 8'h20);
        second();
        chk("R5", "2023 not leap", month, 8'h03);
        load(8'h59, 8'h59, 8'h23, 8'h02, 8'h29, 8'h02, 8'h24, 8'h20);
        second();
        chk("R5", "Feb 29 to Mar 1", date, 8'h01);
    endtask

    task automatic t_spring();
        bin_mode = 1'b0; hr24 = 1'b0; dst_en = 1'b1;
        load(8'h59, 8'h59, 8'h01, 8'h01, 8'h02, 8'h04, 8'h23, 8'h20);
        second();
        chk("R10", "spring hour", hour, 8'h03);
        chk("R10", "spring min", min, 8'h00);
        chk("R10", "spring sec", sec, 8'h00);
        dst_en = 1'b0;
        load(8'h59, 8'h59, 8'h01, 8'h01, 8'h02, 8'h04, 8'h23, 8'h20);
        second();
        chk("R10", "no jump when disabled", hour, 8'h02);
        hr24 = 1'b1;
    endtask

    task automatic t_autumn();
        bin_mode = 1'b0; hr24 = 1'b1; dst_en = 1'b1;
        load(8'h59, 8'h59, 8'h01, 8'h01, 8'h29, 8'h10, 8'h23, 8'h20);
        second();
        chk("R11", "fallback hour", hour, 8'h01);
        chk("R11", "fallback min", min, 8'h00);
        wr(3'd1, 8'h59); wr(3'd0, 8'h59);
        second();
        chk("R11", "second pass proceeds", hour, 8'h02);
        chk("R11", "date kept", date, 8'h29);
        dst_en = 1'b0;
    endtask

    task automatic t_set_inhibit();
        bin_mode = 1'b0; hr24 = 1'b1;
        load(8'h20, 8'h10, 8'h05, 8'h01, 8'h01, 8'h01, 8'h00, 8'h20);
        set_mode = 1'b1;
        fork
            second();
            begin : mon
                int seen = 0;
                repeat (2 * (UIPN + 5)) begin
                    @(negedge clk);
                    if (uip) seen++;
                end
                chk("R8", "uip stays low in SET", 8'(seen), 8'h00);
            end
        join
        chk("R8", "no update in SET", sec, 8'h20);
        set_mode = 1'b0;
        second();
        chk("R8", "updates after SET cleared", sec, 8'h21);
    endtask

    task automatic t_divider();
        wr(3'd0, 8'h40);
        dv = 3'b000;
        pulse_tick(); pulse_tick(); pulse_tick();
        chk("R9", "oscillator off ignores ticks", sec, 8'h40);
        @(negedge clk); dv = 3'b110;
        @(negedge clk);
        chk("R9", "uip low in chain reset", {7'd0, uip}, 8'h00);
        dv = 3'b010;
        pulse_tick();
        chk("R9", "first tick after reset updates", sec, 8'h41);
        pulse_tick();
        chk("R9", "next tick idle", sec, 8'h41);
        pulse_tick();
        chk("R9", "following tick updates", sec, 8'h42);
        pulse_tick();
    endtask

    task automatic t_write_port();
        wr(3'd0, 8'hB5);
        chk("R12", "seconds bit7 read-only", sec, 8'h35);
        wr(3'd4, 8'h17);
        chk("R12", "date byte at index 4", date, 8'h17);
        wr(3'd7, 8'h19);
        chk("R12", "century at index 7", cent, 8'h19);
        chk("R12", "year untouched", year, 8'h00);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL R7 watchdog: actual=hung expected=complete");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_uip_window();
        t_bcd_rollover();
        t_binary();
        t_twelve_hour();
        t_leap();
        t_spring();
        t_autumn();
        t_set_inhibit();
        t_divider();
        t_write_port();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule